// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the command pins of one four-bank SDRAM with a 32-bit data bus. After reset it brings the device up by itself. It closes every bank, runs a fixed number of refresh cycles and then writes the mode register. From then on it serves single-beat user requests. Each request names a bank, a row, a column, a direction and whether the bank should close itself after the burst. Data moves on a separate path. This block only decides which command goes out on which cycle.

Each bank keeps its row open between requests. A request that hits the open row gets its column command directly. A request to another row first closes the bank and then reopens it. A request to an idle bank starts with an activate. Per-bank down-counters enforce the timing minimums between commands. Shared counters space out activates, column bursts and mode register writes. A free-running interval counter raises a refresh demand. That demand outranks user traffic: the block closes all open banks with one precharge-all, waits for them to settle and then issues the refresh.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The command is driven as {cs_n,ras_n,cas_n,we_n}: 0000 mode write, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0111 no-operation. During reset the pins hold no-operation, with bank and address zero, and init_done and req_ready low.
- R2: After reset the first commands are, in order: a precharge with address bit 10 high, two refreshes and one mode write. init_done goes high on the cycle the mode write is on the pins. No activate, read or write appears before that.
- R3: The mode write carries the burst-length code in A2:A0 (1→0, 2→1, 4→2, 8→3, full page→7), the burst type in A3 (1 = interleaved) and the CAS latency in A6:A4, with all other address bits zero. With the defaults (burst 4, sequential, latency 3) the word is 0x032.
- R4: An activate puts the bank on BA1:BA0 and the row on A10:A0. A read or write puts the bank on BA1:BA0 and the column on A7:A0, with A9:A8 zero and A10 equal to the auto-precharge flag of the request.
- R5: A read or write to a bank comes at least 3 cycles after the activate of that bank.
- R6: A precharge of a bank comes at least 7 cycles after its activate and at least BL-1+2 cycles after a write command to it (2 cycles after its last data beat).
- R7: Two activates to the same bank are at least 10 cycles apart. Activates to different banks are at least 2 cycles apart.
- R8: An activate comes at least 3 cycles after a precharge of that bank. After an auto-precharge read, it comes at least 3 cycles after the end of the burst (BL cycles after the read). After an auto-precharge write, it comes at least 3 cycles after BL-1+2 cycles from the write.
- R9: The cycle after a mode write carries no-operation, so the next command is at least 2 cycles later.
- R10: A refresh or mode write is issued only while every bank is closed. When a refresh is due with banks open, a precharge with A10 high closes them first.
- R11: After initialization, a refresh is issued once per REF_INT cycles. Each gap between refreshes stays within 30 cycles of REF_INT.
- R12: A request to the open row of its bank issues no activate. A request to a different row issues exactly one precharge of that bank and one activate before its column command.
- R13: req_ready is high for one cycle per accepted request, only after init_done. The next cycle carries that request's read (req_write low) or write (req_write high) on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_autopre | input | 1 | Close the bank after this burst |
| req_ready | output | 1 | Request taken on this edge |
| init_done | output | 1 | Device programmed, requests served |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |

## Verification
A command is decided combinationally and registered onto the pins. A request seen with req_ready high at a falling edge is therefore checked at the very next falling edge, one cycle later, where its read or write must be on the pins. Every timing minimum is measured by a bench monitor. The monitor samples the pins at each falling edge and subtracts the cycle numbers of the related commands it has logged, so each gap is judged on the cycle the second command actually appears. Refresh spacing and the order of the power-up commands are checked the same way, from the logged command stream rather than from fixed delays.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int ROW_W            = 11,
  parameter int COL_W            = 8,
  parameter int BA_W             = 2,
  parameter int ADDR_W           = 11,
  parameter int T_RCD            = 3,
  parameter int T_RP             = 3,
  parameter int T_RAS            = 7,
  parameter int T_RC             = 10,
  parameter int T_RRD            = 2,
  parameter int T_WR             = 2,
  parameter int T_MRD            = 2,
  parameter int BURST_LEN        = 4,
  parameter int CAS_LAT          = 3,
  parameter int BURST_INTERLEAVE = 0,
  parameter int INIT_REFS        = 2,
  parameter int REF_INT          = 2600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_autopre,
  output logic              req_ready,
  output logic              init_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int NB = 1 << BA_W;
  localparam int AP = 10;
  localparam int CW = $clog2(T_RC + T_RAS + BURST_LEN + T_WR + T_RP + 2);
  localparam int RW = $clog2(REF_INT + 1);

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                         C_NOP = 4'b0111;

  localparam logic [2:0] BL_CODE = (BURST_LEN == 1) ? 3'd0 : (BURST_LEN == 2) ? 3'd1 :
                                   (BURST_LEN == 4) ? 3'd2 : (BURST_LEN == 8) ? 3'd3 : 3'd7;
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({3'(CAS_LAT), 1'(BURST_INTERLEAVE), BL_CODE});

  localparam logic [CW-1:0] D_RCD    = CW'(T_RCD - 1);
  localparam logic [CW-1:0] D_RP     = CW'(T_RP - 1);
  localparam logic [CW-1:0] D_RAS    = CW'(T_RAS - 1);
  localparam logic [CW-1:0] D_RC     = CW'(T_RC - 1);
  localparam logic [CW-1:0] D_RRD    = CW'(T_RRD - 1);
  localparam logic [CW-1:0] D_MRD    = CW'(T_MRD - 1);
  localparam logic [CW-1:0] D_COL    = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] D_RD_PRE = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] D_WR_PRE = CW'(BURST_LEN + T_WR - 2);
  localparam logic [CW-1:0] D_RDA    = CW'(BURST_LEN + T_RP - 1);
  localparam logic [CW-1:0] D_WRA    = CW'(BURST_LEN + T_WR + T_RP - 2);
  localparam logic [RW-1:0] REF_LAST = RW'(REF_INT - 1);
  localparam logic [2:0]    N_REF    = 3'(INIT_REFS);

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CW-1:0]    col_ok [NB];
  logic [CW-1:0]    pre_ok [NB];
  logic [CW-1:0]    act_ok [NB];
  logic [ROW_W-1:0] row_q  [NB];
  logic [NB-1:0]    open_q;
  logic [CW-1:0]    colg, rrd, mrd;
  logic [RW-1:0]    ref_tmr;
  logic             ref_pend;
  logic [2:0]       init_step;

  logic [3:0]        cmd;
  logic [BA_W-1:0]   ba;
  logic [ADDR_W-1:0] addr;
  logic              accept, all_act_ok, open_pre_ok, hit;

  assign hit       = open_q[req_bank] && (row_q[req_bank] == req_row);
  assign req_ready = accept;

  always_comb begin
    all_act_ok  = 1'b1;
    open_pre_ok = 1'b1;
    for (int i = 0; i < NB; i++) begin
      if (act_ok[i] != '0) all_act_ok = 1'b0;
      if (open_q[i] && pre_ok[i] != '0) open_pre_ok = 1'b0;
    end
  end

  always_comb begin
    cmd    = C_NOP;
    ba     = '0;
    addr   = '0;
    accept = 1'b0;
    if (mrd != '0) begin
      cmd = C_NOP;
    end else if (!init_done) begin
      if (init_step == 3'd0) begin
        if (open_pre_ok) begin
          cmd      = C_PRE;
          addr[AP] = 1'b1;
        end
      end else if (all_act_ok) begin
        if (init_step <= N_REF) cmd = C_REF;
        else begin
          cmd  = C_MRS;
          addr = MODE_WORD;
        end
      end
    end else if (ref_pend) begin
      if (open_q != '0) begin
        if (open_pre_ok) begin
          cmd      = C_PRE;
          addr[AP] = 1'b1;
        end
      end else if (all_act_ok) begin
        cmd = C_REF;
      end
    end else if (req_valid) begin
      if (hit) begin
        if (col_ok[req_bank] == '0 && colg == '0) begin
          cmd      = req_write ? C_WR : C_RD;
          ba       = req_bank;
          addr     = ADDR_W'(req_col);
          addr[AP] = req_autopre;
          accept   = 1'b1;
        end
      end else if (open_q[req_bank]) begin
        if (pre_ok[req_bank] == '0) begin
          cmd = C_PRE;
          ba  = req_bank;
        end
      end else if (act_ok[req_bank] == '0 && rrd == '0) begin
        cmd  = C_ACT;
        ba   = req_bank;
        addr = ADDR_W'(req_row);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= C_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      colg      <= '0;
      rrd       <= '0;
      mrd       <= '0;
      ref_tmr   <= '0;
      ref_pend  <= 1'b0;
      init_step <= '0;
      init_done <= 1'b0;
      open_q    <= '0;
      for (int i = 0; i < NB; i++) begin
        col_ok[i] <= '0;
        pre_ok[i] <= '0;
        act_ok[i] <= '0;
        row_q[i]  <= '0;
      end
    end else begin
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd;
      sd_ba   <= ba;
      sd_addr <= addr;
      colg <= (cmd == C_RD || cmd == C_WR) ? D_COL : dec(colg);
      rrd  <= (cmd == C_ACT) ? D_RRD : dec(rrd);
      mrd  <= (cmd == C_MRS) ? D_MRD : dec(mrd);
      if (!init_done && cmd != C_NOP) begin
        init_step <= init_step + 3'd1;
        if (cmd == C_MRS) init_done <= 1'b1;
      end
      if (init_done) begin
        if (cmd == C_REF) ref_pend <= 1'b0;
        if (ref_tmr == REF_LAST) begin
          ref_tmr  <= '0;
          ref_pend <= 1'b1;
        end else begin
          ref_tmr <= ref_tmr + 1'b1;
        end
      end
      for (int i = 0; i < NB; i++) begin
        col_ok[i] <= dec(col_ok[i]);
        pre_ok[i] <= dec(pre_ok[i]);
        act_ok[i] <= dec(act_ok[i]);
        case (cmd)
          C_ACT: if (ba == BA_W'(i)) begin
            open_q[i] <= 1'b1;
            row_q[i]  <= addr[ROW_W-1:0];
            col_ok[i] <= mx(dec(col_ok[i]), D_RCD);
            pre_ok[i] <= mx(dec(pre_ok[i]), D_RAS);
            act_ok[i] <= mx(dec(act_ok[i]), D_RC);
          end
          C_PRE: if (addr[AP] || ba == BA_W'(i)) begin
            open_q[i] <= 1'b0;
            act_ok[i] <= mx(dec(act_ok[i]), D_RP);
          end
          C_RD, C_WR: if (ba == BA_W'(i)) begin
            pre_ok[i] <= mx(dec(pre_ok[i]), (cmd == C_WR) ? D_WR_PRE : D_RD_PRE);
            if (addr[AP]) begin
              open_q[i] <= 1'b0;
              act_ok[i] <= mx(dec(act_ok[i]), (cmd == C_WR) ? D_WRA : D_RDA);
            end
          end
          C_REF: act_ok[i] <= mx(dec(act_ok[i]), D_RC);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_write,
  input logic              init_done,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr
);
  logic [3:0] pc;
  assign pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    pc == 4'b0000 |=> pc == 4'b0111); // R9

  AST_ACCEPT_COL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> pc == ($past(req_write) ? 4'b0100 : 4'b0101)); // R13

  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done); // R13

  AST_RCD_NOCOL: assert property (@(posedge clk) disable iff (!rst_n)
    pc == 4'b0011 |=> !((pc == 4'b0101 || pc == 4'b0100) && sd_ba == $past(sd_ba))); // R5

  AST_INIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !(pc == 4'b0011 || pc == 4'b0101 || pc == 4'b0100)); // R2
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_write(req_write),
  .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
  localparam int REF_INT = 500;
  localparam int BL = 4;
  localparam logic [10:0] MODE = 11'h032;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                         C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
  logic [1:0] req_bank = '0;
  logic [10:0] req_row = '0;
  logic [7:0] req_col = '0;
  logic req_ready, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [10:0] sd_addr;

  sdram_cmd_seq #(.REF_INT(REF_INT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_ready(req_ready), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  int t_act[4], t_pre[4], t_wr[4], act_row[4];
  bit bopen[4];
  int t_act_any = -1000, t_mrs = -1000, t_ref_run = -1;
  int n_act = 0, n_pre = 0, n_ref_run = 0, n_pall_run = 0, n_log = 0;
  logic [3:0] log_cmd[8];
  logic [10:0] log_addr[8];

  initial for (int i = 0; i < 4; i++) begin
    t_act[i] = -1000; t_pre[i] = -1000; t_wr[i] = -1000; bopen[i] = 0; act_row[i] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    logic [3:0] pc;
    int b;
    pc = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    b = int'(sd_ba);
    if (pc != C_NOP) begin
      if (!init_done || pc == C_MRS) begin
        if (n_log < 8) begin
          log_cmd[n_log] = pc; log_addr[n_log] = sd_addr; n_log++;
        end
      end
      if (pc != C_MRS)
        chk(cyc - t_mrs >= 2, "R9", $sformatf("gap after mode write %0d exp >=2", cyc - t_mrs));
    end
    case (pc)
      C_MRS: begin
        chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R10", "mode write with open bank");
        chk(sd_addr == MODE, "R3", $sformatf("mode word %h exp %h", sd_addr, MODE));
        t_mrs = cyc;
      end
      C_REF: begin
        chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R10", "refresh with open bank");
        if (init_done) begin
          if (t_ref_run >= 0)
            chk(cyc - t_ref_run >= REF_INT - 30 && cyc - t_ref_run <= REF_INT + 30, "R11",
                $sformatf("refresh gap %0d exp %0d+-30", cyc - t_ref_run, REF_INT));
          t_ref_run = cyc;
          n_ref_run++;
        end
      end
      C_ACT: begin
        chk(!bopen[b], "R12", "activate of open bank");
        chk(cyc - t_act[b] >= 10, "R7", $sformatf("same-bank act gap %0d exp >=10", cyc - t_act[b]));
        chk(cyc - t_act_any >= 2, "R7", $sformatf("act-act gap %0d exp >=2", cyc - t_act_any));
        chk(cyc - t_pre[b] >= 3, "R8", $sformatf("pre-act gap %0d exp >=3", cyc - t_pre[b]));
        bopen[b] = 1; t_act[b] = cyc; t_act_any = cyc; act_row[b] = int'(sd_addr); n_act++;
      end
      C_RD, C_WR: begin
        chk(bopen[b], "R4", "column command to closed bank");
        chk(cyc - t_act[b] >= 3, "R5", $sformatf("act-col gap %0d exp >=3", cyc - t_act[b]));
        if (pc == C_WR) t_wr[b] = cyc;
        if (sd_addr[10]) begin
          bopen[b] = 0;
          t_pre[b] = cyc + ((pc == C_WR) ? BL - 1 + 2 : BL);
        end
      end
      C_PRE: begin
        n_pre++;
        if (init_done && sd_addr[10]) n_pall_run++;
        for (int i = 0; i < 4; i++) if (sd_addr[10] || i == b) begin
          if (bopen[i]) begin
            chk(cyc - t_act[i] >= 7, "R6", $sformatf("act-pre gap %0d exp >=7", cyc - t_act[i]));
            chk(cyc - t_wr[i] >= BL - 1 + 2, "R6", $sformatf("wr-pre gap %0d exp >=%0d", cyc - t_wr[i], BL + 1));
          end
          bopen[i] = 0;
          if (cyc > t_pre[i]) t_pre[i] = cyc;
        end
      end
      default: ;
    endcase
  end

  task automatic do_req(input int b, input int row, input int col, input bit wr, input bit ap);
    int k;
    @(negedge clk);
    req_valid = 1; req_bank = 2'(b); req_row = 11'(row); req_col = 8'(col);
    req_write = wr; req_autopre = ap;
    #1;
    k = 0;
    while (!req_ready && k < 300) begin
      @(negedge clk); #1; k++;
    end
    if (!req_ready) begin
      chk(0, "R13", "req_ready 0 exp 1 (timeout)");
      req_valid = 0;
      return;
    end
    @(negedge clk);
    req_valid = 0;
    #1;
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == (wr ? C_WR : C_RD), "R13",
        $sformatf("cmd %b exp %b", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, wr ? C_WR : C_RD));
    chk(sd_ba == 2'(b) && sd_addr == {ap, 2'b00, 8'(col)}, "R4",
        $sformatf("ba/addr %0d/%h exp %0d/%h", sd_ba, sd_addr, b, {ap, 2'b00, 8'(col)}));
  endtask

  task automatic t_reset;
    #1;
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_ba == 0 && sd_addr == 0, "R1",
        $sformatf("reset pins %b/%0d/%h exp 0111/0/0", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, sd_ba, sd_addr));
    chk(!init_done && !req_ready, "R1", $sformatf("init_done/ready %b%b exp 00", init_done, req_ready));
  endtask

  task automatic t_init;
    int k = 0;
    while (!init_done && k < 200) begin @(negedge clk); k++; end
    #1;
    chk(init_done, "R2", "init_done 0 exp 1");
    chk(n_log >= 4, "R2", $sformatf("init commands %0d exp 4", n_log));
    chk(log_cmd[0] == C_PRE && log_addr[0][10], "R2", $sformatf("first %b/%h exp 0010 A10=1", log_cmd[0], log_addr[0]));
    chk(log_cmd[1] == C_REF && log_cmd[2] == C_REF, "R2", $sformatf("2nd,3rd %b %b exp 0001", log_cmd[1], log_cmd[2]));
    chk(log_cmd[3] == C_MRS && log_addr[3] == MODE, "R3", $sformatf("4th %b/%h exp 0000/%h", log_cmd[3], log_addr[3], MODE));
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_MRS, "R2", "init_done not aligned with mode write");
  endtask

  task automatic t_hit_miss;
    int a0, p0;
    do_req(0, 5, 8, 1, 0);
    chk(act_row[0] == 5, "R4", $sformatf("act row %0d exp 5", act_row[0]));
    a0 = n_act; p0 = n_pre;
    do_req(0, 5, 9, 0, 0);
    chk(n_act == a0 && n_pre == p0, "R12", $sformatf("hit act/pre %0d/%0d exp %0d/%0d", n_act, n_pre, a0, p0));
    do_req(0, 7, 10, 0, 0);
    chk(n_act == a0 + 1 && n_pre == p0 + 1, "R12", $sformatf("miss act/pre %0d/%0d exp %0d/%0d", n_act, n_pre, a0 + 1, p0 + 1));
    chk(act_row[0] == 7, "R4", $sformatf("act row %0d exp 7", act_row[0]));
  endtask

  task automatic t_autopre;
    int a0, p0;
    do_req(1, 3, 4, 1, 1);
    a0 = n_act; p0 = n_pre;
    do_req(1, 3, 5, 0, 1);
    chk(n_act == a0 + 1 && n_pre == p0, "R8", $sformatf("reopen act/pre %0d/%0d exp %0d/%0d", n_act, n_pre, a0 + 1, p0));
    do_req(1, 3, 6, 1, 0);
  endtask

  task automatic t_interleave;
    do_req(2, 100, 1, 0, 0);
    do_req(3, 200, 2, 1, 0);
    do_req(0, 300, 3, 1, 0);
    do_req(3, 201, 4, 0, 0);
    do_req(2, 100, 5, 1, 1);
  endtask

  task automatic t_refresh;
    int r0, q0;
    do_req(2, 50, 7, 1, 0);
    r0 = n_ref_run; q0 = n_pall_run;
    repeat (1100) @(negedge clk);
    chk(n_ref_run >= r0 + 2, "R11", $sformatf("refreshes %0d exp >=%0d", n_ref_run, r0 + 2));
    chk(n_pall_run >= q0 + 1, "R10", $sformatf("precharge-all %0d exp >=%0d", n_pall_run, q0 + 1));
    do_req(2, 50, 8, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R13", "watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_init();
    t_hit_miss();
    t_autopre();
    t_interleave();
    t_refresh();
    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule